// File: doc/BRIEF.md
# Packed Subword SIMD ALU

This block is a one-stage integer datapath that treats each 64-bit source as a single 64-bit value or as a vector of equal-width lanes of 32, 16 or 8 bits. Each cycle it takes two sources, an operation code, a lane-width select and a signedness flag, and registers one 64-bit result. Carries and borrows stop at lane edges. Saturating arithmetic clamps each lane on its own. Compares write a full mask into each lane. Pack narrows lanes with saturation, and unpack interleaves the lanes of both sources. The 16-bit multiplier family includes a form that sums adjacent products. Shifts are bounded by the lane width, and bitwise logic spans the full word.

A scheduler that issues packed media or signal-processing operations places it in its execute stage. The result appears one clock after the operands. Any mix of operation and lane width that the block does not define produces a zero result and has no other effect.

Top module: `subword_alu`

## Requirements
- R1: While rst_n is low, result_o is zero. Inputs present at a rising clock edge appear on result_o after that edge, and result_o does not change before it.
- R2: op codes 0 (add) and 2 (subtract) work lane by lane with wrap-around and never carry or borrow into the next lane. lane_sz_i selects 0 = eight 8-bit lanes, 1 = four 16-bit lanes, 2 = two 32-bit lanes and 3 = one 64-bit lane. Lane k occupies bits [k*W+W-1 : k*W].
- R3: op codes 1 (add) and 3 (subtract) saturate per lane, at every lane width. With sat_signed_i = 1 a lane clamps to the most positive or most negative two's-complement value. With sat_signed_i = 0 it clamps to all ones or to zero.
- R4: op code 4 (equal) and op code 5 (signed greater: src_a lane > src_b lane) write all ones into a lane where the condition holds and all zeros elsewhere. They are defined for lane_sz_i 0, 1 and 2.
- R5: op code 6 narrows each lane to half its width, for lane_sz_i 1 (16 to 8) and 2 (32 to 16). The narrowed lanes of src_a fill the low half of the result in lane order, and those of src_b fill the high half. The inputs are taken as signed. sat_signed_i = 1 clamps to the signed range of the narrow lane, and sat_signed_i = 0 clamps to the unsigned range.
- R6: op code 7 interleaves the low-half lanes of the two sources, and op code 8 the high-half lanes. Even result lanes come from src_a and odd lanes from src_b, in ascending order. They are defined for lane_sz_i 0, 1 and 2.
- R7: op code 9 (low half) and op code 10 (high half) multiply the four signed 16-bit lanes and keep the chosen 16 bits of each 32-bit product. lane_sz_i is ignored.
- R8: op code 11 forms the four signed 16-bit products and adds lanes 0+1 and 2+3, giving two 32-bit results with wrap-around. lane_sz_i is ignored.
- R9: op code 12 (left) and op code 13 (right) are logical shifts for lane_sz_i 1, 2 and 3. The count is the whole of src_b_i taken as unsigned, and a count at or above the lane width gives zero.
- R10: op code 14 is an arithmetic right shift for lane_sz_i 1 and 2. A count at or above the lane width fills the lane with its sign bit.
- R11: op codes 15 (a AND b), 16 ((NOT a) AND b), 17 (OR) and 18 (XOR) act bitwise on all 64 bits for any lane_sz_i.
- R12: op codes 19 to 31, and any defined op code used with a lane_sz_i outside its supported set, give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 5 | Operation code |
| lane_sz_i | input | 2 | Lane width select |
| sat_signed_i | input | 1 | Signed (1) or unsigned (0) saturation |
| src_a_i | input | 64 | First source |
| src_b_i | input | 64 | Second source, also the shift count |
| result_o | output | 64 | Registered result |

## Verification
On every cycle, the assertions check the following: undefined op codes give zero, 8-bit compares produce only whole-lane masks, 64-bit unsigned saturation never wraps past either operand, over-range logical shifts clear the word, and 16-bit arithmetic shifts keep each lane's sign. Only the directed scenarios can show the following: exact per-lane values at lane edges, the lane order of pack and unpack, the product halves, the adjacent-pair sums, and the unsupported width combinations other than undefined op codes.

// File: rtl/simd_pkg.sv
package simd_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDS  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBS  = 5'd3,
      OP_CEQ   = 5'd4,
      OP_CGT   = 5'd5,
      OP_PACK  = 5'd6,
      OP_UNLO  = 5'd7,
      OP_UNHI  = 5'd8,
      OP_MULLO = 5'd9,
      OP_MULHI = 5'd10,
      OP_MADD  = 5'd11,
      OP_SHL   = 5'd12,
      OP_SHR   = 5'd13,
      OP_SAR   = 5'd14,
      OP_AND   = 5'd15,
      OP_ANDN  = 5'd16,
      OP_OR    = 5'd17,
      OP_XOR   = 5'd18
   } simd_op_e;

   localparam int OP_LAST = 18;

endpackage

// File: rtl/simd_lane_arith.sv
// Add/sub (wrap and saturate), compares and shifts for one lane width.
module simd_lane_arith #(
   parameter int DATA_W = 64,
   parameter int LW     = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              sat_signed_i,
   output logic [DATA_W-1:0] wrap_o,
   output logic [DATA_W-1:0] sat_o,
   output logic [DATA_W-1:0] eq_o,
   output logic [DATA_W-1:0] gt_o,
   output logic [DATA_W-1:0] shl_o,
   output logic [DATA_W-1:0] shr_o,
   output logic [DATA_W-1:0] sar_o
);
   localparam int NL  = DATA_W / LW;
   localparam int SHW = $clog2(LW);
   localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
   localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

   // any count bit at or above log2(LW) means the shift empties the lane
   logic           cnt_big;
   logic [SHW-1:0] amt;
   assign cnt_big = |b_i[DATA_W-1:SHW];
   assign amt     = b_i[SHW-1:0];

   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0]        la, lb, lr, ls;
      logic [LW:0]          ext;
      logic                 ovf_s;
      logic signed [LW-1:0] sra;

      assign la  = a_i[i*LW +: LW];
      assign lb  = b_i[i*LW +: LW];
      assign ext = sub_i ? ({1'b0, la} - {1'b0, lb}) : ({1'b0, la} + {1'b0, lb});
      assign lr  = ext[LW-1:0];
      assign ovf_s = (sub_i ? (la[LW-1] != lb[LW-1]) : (la[LW-1] == lb[LW-1]))
                     && (lr[LW-1] != la[LW-1]);

      always_comb begin
         if (sat_signed_i)
            ls = ovf_s ? (la[LW-1] ? SMIN : SMAX) : lr;
         else
            ls = ext[LW] ? (sub_i ? '0 : '1) : lr;
      end

      assign sra = $signed(la) >>> amt;

      assign wrap_o[i*LW +: LW] = lr;
      assign sat_o [i*LW +: LW] = ls;
      assign eq_o  [i*LW +: LW] = {LW{la == lb}};
      assign gt_o  [i*LW +: LW] = {LW{$signed(la) > $signed(lb)}};
      assign shl_o [i*LW +: LW] = cnt_big ? '0 : (la << amt);
      assign shr_o [i*LW +: LW] = cnt_big ? '0 : (la >> amt);
      assign sar_o [i*LW +: LW] = cnt_big ? {LW{la[LW-1]}} : sra;
   end
endmodule

// File: rtl/simd_perm.sv
// Saturating narrow (pack) and interleave (unpack) for one lane width.
module simd_perm #(
   parameter int DATA_W = 64,
   parameter int LW     = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sat_signed_i,
   output logic [DATA_W-1:0] pack_o,
   output logic [DATA_W-1:0] unlo_o,
   output logic [DATA_W-1:0] unhi_o
);
   localparam int HW = LW / 2;
   localparam int NL = DATA_W / LW;
   localparam int NH = NL / 2;
   localparam logic [HW-1:0] NMAX = {1'b0, {(HW-1){1'b1}}};
   localparam logic [HW-1:0] NMIN = {1'b1, {(HW-1){1'b0}}};

   for (genvar i = 0; i < 2*NL; i++) begin : g_pack
      logic [LW-1:0] x;
      logic          s_fit, u_fit;
      if (i < NL) begin : g_a
         assign x = a_i[i*LW +: LW];
      end else begin : g_b
         assign x = b_i[(i-NL)*LW +: LW];
      end
      // fits signed when the top HW+1 bits all match the sign
      assign s_fit = (x[LW-1:HW-1] == {(HW+1){x[LW-1]}});
      assign u_fit = (x[LW-1:HW] == '0);
      assign pack_o[i*HW +: HW] = sat_signed_i
         ? (s_fit ? x[HW-1:0] : (x[LW-1] ? NMIN : NMAX))
         : (u_fit ? x[HW-1:0] : (x[LW-1] ? '0 : '1));
   end

   if (NH > 0) begin : g_unpack
      for (genvar i = 0; i < NH; i++) begin : g_il
         assign unlo_o[(2*i)*LW   +: LW] = a_i[i*LW +: LW];
         assign unlo_o[(2*i+1)*LW +: LW] = b_i[i*LW +: LW];
         assign unhi_o[(2*i)*LW   +: LW] = a_i[(NH+i)*LW +: LW];
         assign unhi_o[(2*i+1)*LW +: LW] = b_i[(NH+i)*LW +: LW];
      end
   end else begin : g_no_unpack
      assign unlo_o = '0;
      assign unhi_o = '0;
   end
endmodule

// File: rtl/simd_mul.sv
// Signed lane multiplier: low half, high half and adjacent-pair sum.
module simd_mul #(
   parameter int DATA_W = 64,
   parameter int MW     = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o,
   output logic [DATA_W-1:0] madd_o
);
   localparam int NM = DATA_W / MW;
   localparam int PW = 2 * MW;

   logic [PW-1:0] prod [NM];

   for (genvar i = 0; i < NM; i++) begin : g_prod
      logic [PW-1:0] ea, eb;
      assign ea = {{MW{a_i[i*MW+MW-1]}}, a_i[i*MW +: MW]};
      assign eb = {{MW{b_i[i*MW+MW-1]}}, b_i[i*MW +: MW]};
      assign prod[i] = $signed(ea) * $signed(eb);
      assign lo_o[i*MW +: MW] = prod[i][MW-1:0];
      assign hi_o[i*MW +: MW] = prod[i][PW-1:MW];
   end

   for (genvar j = 0; j < NM/2; j++) begin : g_pair
      assign madd_o[j*PW +: PW] = prod[2*j] + prod[2*j+1];
   end
endmodule

// File: rtl/subword_alu.sv
module subword_alu
   import simd_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int LANE_MIN = 8,
   parameter int MUL_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        op_i,
   input  logic [1:0]        lane_sz_i,
   input  logic              sat_signed_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   output logic [DATA_W-1:0] result_o
);
   localparam int NS  = $clog2(DATA_W / LANE_MIN) + 1;
   localparam int SZW = $clog2(NS);
   localparam logic [1:0] SZ_TOP = 2'(NS - 1);
   localparam logic [1:0] SZ_MIN = 2'd0;

   // elaboration-time parameter checks
   if (DATA_W != (LANE_MIN << (NS - 1))) begin : g_chk_pow2
      $error("DATA_W must be LANE_MIN times a power of two");
   end
   if (NS != (1 << SZW) || SZW != 2) begin : g_chk_sel
      $error("lane-width select must cover exactly four widths");
   end
   if ((DATA_W % (2 * MUL_W)) != 0) begin : g_chk_mul
      $error("DATA_W must hold an even number of multiplier lanes");
   end

   simd_op_e op;
   logic     sub;
   assign op  = simd_op_e'(op_i);
   assign sub = (op == OP_SUB) || (op == OP_SUBS);

   logic [DATA_W-1:0] wrap_v [NS], sat_v [NS], eq_v [NS], gt_v [NS];
   logic [DATA_W-1:0] shl_v  [NS], shr_v [NS], sar_v [NS];
   logic [DATA_W-1:0] pack_v [NS], unlo_v [NS], unhi_v [NS];
   logic [DATA_W-1:0] mlo, mhi, madd;

   for (genvar s = 0; s < NS; s++) begin : g_width
      simd_lane_arith #(.DATA_W(DATA_W), .LW(LANE_MIN << s)) u_arith (
         .a_i(src_a_i), .b_i(src_b_i), .sub_i(sub), .sat_signed_i(sat_signed_i),
         .wrap_o(wrap_v[s]), .sat_o(sat_v[s]), .eq_o(eq_v[s]), .gt_o(gt_v[s]),
         .shl_o(shl_v[s]), .shr_o(shr_v[s]), .sar_o(sar_v[s]));
      simd_perm #(.DATA_W(DATA_W), .LW(LANE_MIN << s)) u_perm (
         .a_i(src_a_i), .b_i(src_b_i), .sat_signed_i(sat_signed_i),
         .pack_o(pack_v[s]), .unlo_o(unlo_v[s]), .unhi_o(unhi_v[s]));
   end

   simd_mul #(.DATA_W(DATA_W), .MW(MUL_W)) u_mul (
      .a_i(src_a_i), .b_i(src_b_i), .lo_o(mlo), .hi_o(mhi), .madd_o(madd));

   logic [DATA_W-1:0] raw, nxt;
   logic              ok;
   logic              not_top, not_min;
   assign not_top = (lane_sz_i != SZ_TOP);
   assign not_min = (lane_sz_i != SZ_MIN);

   always_comb begin
      raw = '0;
      ok  = 1'b1;
      case (op)
         OP_ADD, OP_SUB:   raw = wrap_v[lane_sz_i];
         OP_ADDS, OP_SUBS: raw = sat_v[lane_sz_i];
         OP_CEQ:   begin raw = eq_v[lane_sz_i];   ok = not_top; end
         OP_CGT:   begin raw = gt_v[lane_sz_i];   ok = not_top; end
         OP_PACK:  begin raw = pack_v[lane_sz_i]; ok = not_top && not_min; end
         OP_UNLO:  begin raw = unlo_v[lane_sz_i]; ok = not_top; end
         OP_UNHI:  begin raw = unhi_v[lane_sz_i]; ok = not_top; end
         OP_MULLO: raw = mlo;
         OP_MULHI: raw = mhi;
         OP_MADD:  raw = madd;
         OP_SHL:   begin raw = shl_v[lane_sz_i];  ok = not_min; end
         OP_SHR:   begin raw = shr_v[lane_sz_i];  ok = not_min; end
         OP_SAR:   begin raw = sar_v[lane_sz_i];  ok = not_top && not_min; end
         OP_AND:   raw = src_a_i & src_b_i;
         OP_ANDN:  raw = ~src_a_i & src_b_i;
         OP_OR:    raw = src_a_i | src_b_i;
         OP_XOR:   raw = src_a_i ^ src_b_i;
         default:  ok = 1'b0;
      endcase
      nxt = ok ? raw : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) result_o <= '0;
      else        result_o <= nxt;
   end

   // ---------------- assertions ----------------
   function automatic logic lanes_are_masks(input logic [DATA_W-1:0] v);
      for (int i = 0; i < DATA_W / LANE_MIN; i++) begin
         if (v[i*LANE_MIN +: LANE_MIN] != '0 && v[i*LANE_MIN +: LANE_MIN] != '1)
            return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic [DATA_W-1:0] sign_bits16();
      logic [DATA_W-1:0] m = '0;
      for (int i = 0; i < DATA_W / (2 * LANE_MIN); i++) m[(i+1)*2*LANE_MIN-1] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] SIGN16 = sign_bits16();

   p_undef_op_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && ($past(op_i) > 5'(OP_LAST)) |-> result_o == '0);

   p_byte_cmp_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && ($past(op_i) == OP_CEQ || $past(op_i) == OP_CGT)
      && $past(lane_sz_i) == SZ_MIN |-> lanes_are_masks(result_o));

   p_usat_add_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(op_i) == OP_ADDS && $past(lane_sz_i) == SZ_TOP
      && !$past(sat_signed_i)
      |-> (result_o >= $past(src_a_i)) && (result_o >= $past(src_b_i)));

   p_usat_sub_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(op_i) == OP_SUBS && $past(lane_sz_i) == SZ_TOP
      && !$past(sat_signed_i) |-> result_o <= $past(src_a_i));

   p_big_shift_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && ($past(op_i) == OP_SHL || $past(op_i) == OP_SHR)
      && $past(src_b_i) >= DATA_W |-> result_o == '0);

   p_sar_keeps_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(op_i) == OP_SAR && $past(lane_sz_i) == 2'd1
      |-> (result_o & SIGN16) == ($past(src_a_i) & SIGN16));

endmodule

// File: tb/tb_subword_alu.sv
module tb_subword_alu;
   import simd_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_i = 5'(OP_ADD);
   logic [1:0]  lane_sz_i = 2'd0;
   logic        sat_signed_i = 1'b0;
   logic [63:0] src_a_i = 64'h1111_2222_3333_4444;
   logic [63:0] src_b_i = 64'h0101_0101_0101_0101;
   logic [63:0] result_o;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   subword_alu dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .lane_sz_i(lane_sz_i),
      .sat_signed_i(sat_signed_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
      .result_o(result_o));

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic run(input string tag, input logic [4:0] op, input logic [1:0] sz,
                      input logic sg, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] exp);
      @(negedge clk);
      op_i = op; lane_sz_i = sz; sat_signed_i = sg; src_a_i = a; src_b_i = b;
      @(negedge clk);
      check(tag, result_o, exp);
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset value", result_o, 64'h0);
      rst_n = 1'b1;
      op_i = 5'(OP_XOR); lane_sz_i = 2'd0; src_a_i = 64'hF; src_b_i = 64'h0;
      #1;
      check("R1 no change before edge", result_o, 64'h0);
      @(negedge clk);
      check("R1 one-cycle latency", result_o, 64'hF);
   endtask

   task automatic t_wrap;
      run("R2 add wrap 8-bit", 5'(OP_ADD), 2'd0, 1'b0, 64'hFF01_8000_7FFF_00FF,
          64'h0101_8001_0001_0001, 64'h0002_0001_7F00_0000);
      run("R2 add wrap 16-bit", 5'(OP_ADD), 2'd1, 1'b0, 64'hFF01_8000_7FFF_00FF,
          64'h0101_8001_0001_0001, 64'h0002_0001_8000_0100);
      run("R2 add wrap 64-bit", 5'(OP_ADD), 2'd3, 1'b0, 64'hFF01_8000_7FFF_00FF,
          64'h0101_8001_0001_0001, 64'h0003_0001_8000_0100);
      run("R2 sub wrap 32-bit", 5'(OP_SUB), 2'd2, 1'b0, 64'h0000_0003_0000_0005,
          64'h0000_0001_0000_0007, 64'h0000_0002_FFFF_FFFE);
   endtask

   task automatic t_sat;
      run("R3 signed sat add 8-bit", 5'(OP_ADDS), 2'd0, 1'b1, 64'h7F8070F005FB0000,
          64'h01FF20E003FD0000, 64'h7F807FD008F80000);
      run("R3 unsigned sat add 8-bit", 5'(OP_ADDS), 2'd0, 1'b0, 64'h7F8070F005FB0000,
          64'h01FF20E003FD0000, 64'h80FF90FF08FF0000);
      run("R3 signed sat sub 16-bit", 5'(OP_SUBS), 2'd1, 1'b1, 64'h8000_7FFF_0005_FFFE,
          64'h0001_FFFF_0007_0001, 64'h8000_7FFF_FFFE_FFFD);
      run("R3 unsigned sat sub 16-bit", 5'(OP_SUBS), 2'd1, 1'b0, 64'h8000_7FFF_0005_FFFE,
          64'h0001_FFFF_0007_0001, 64'h7FFF_0000_0000_FFFD);
      run("R3 unsigned sat add 64-bit", 5'(OP_ADDS), 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0,
          64'h20, 64'hFFFF_FFFF_FFFF_FFFF);
      run("R3 unsigned sat sub 64-bit", 5'(OP_SUBS), 2'd3, 1'b0, 64'h5, 64'h9, 64'h0);
   endtask

   task automatic t_cmp;
      run("R4 equal 8-bit", 5'(OP_CEQ), 2'd0, 1'b0, 64'h0102030405060708,
          64'h0100030005000700, 64'hFF00FF00FF00FF00);
      run("R4 greater 16-bit", 5'(OP_CGT), 2'd1, 1'b0, 64'h7FFF_8000_0001_FFFF,
          64'h8000_7FFF_0001_0000, 64'hFFFF_0000_0000_0000);
      run("R4 greater 32-bit", 5'(OP_CGT), 2'd2, 1'b0, 64'h0000_0002_FFFF_FFFF,
          64'h0000_0001_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_pack;
      run("R5 pack 16->8 signed", 5'(OP_PACK), 2'd1, 1'b1, 64'h0100_FF00_007F_FFF0,
          64'h0000_0001_8000_7FFF, 64'h0001_807F_7F80_7FF0);
      run("R5 pack 16->8 unsigned", 5'(OP_PACK), 2'd1, 1'b0, 64'h0100_FF00_007F_FFF0,
          64'h0000_0001_8000_7FFF, 64'h0001_00FF_FF00_7F00);
      run("R5 pack 32->16 signed", 5'(OP_PACK), 2'd2, 1'b1, 64'h0001_0000_FFFF_8000,
          64'h0000_1234_FFFE_0000, 64'h1234_8000_7FFF_8000);
   endtask

   task automatic t_unpack;
      run("R6 unpack low 8-bit", 5'(OP_UNLO), 2'd0, 1'b0, 64'h8877665544332211,
          64'hFFEEDDCCBBAA9988, 64'hBB44AA3399228811);
      run("R6 unpack high 16-bit", 5'(OP_UNHI), 2'd1, 1'b0, 64'h8877665544332211,
          64'hFFEEDDCCBBAA9988, 64'hFFEE_8877_DDCC_6655);
      run("R6 unpack low 32-bit", 5'(OP_UNLO), 2'd2, 1'b0, 64'h8877665544332211,
          64'hFFEEDDCCBBAA9988, 64'hBBAA9988_44332211);
   endtask

   task automatic t_mul;
      run("R7 multiply low", 5'(OP_MULLO), 2'd0, 1'b0, 64'h8000_7FFF_FFFF_0003,
          64'h8000_7FFF_0002_0004, 64'h0000_0001_FFFE_000C);
      run("R7 multiply high", 5'(OP_MULHI), 2'd3, 1'b0, 64'h8000_7FFF_FFFF_0003,
          64'h8000_7FFF_0002_0004, 64'h4000_3FFF_FFFF_0000);
   endtask

   task automatic t_madd;
      run("R8 multiply-add", 5'(OP_MADD), 2'd1, 1'b0, 64'h8000_7FFF_FFFF_0003,
          64'h8000_7FFF_0002_0004, 64'h7FFF0001_0000000A);
      run("R8 multiply-add wrap", 5'(OP_MADD), 2'd0, 1'b0, 64'h8000_8000_0000_0000,
          64'h8000_8000_0000_0000, 64'h80000000_00000000);
   endtask

   task automatic t_lshift;
      run("R9 left 16-bit", 5'(OP_SHL), 2'd1, 1'b0, 64'h8001_0001_00FF_FFFF,
          64'd4, 64'h0010_0010_0FF0_FFF0);
      run("R9 right 32-bit", 5'(OP_SHR), 2'd2, 1'b0, 64'h8000_00FF_1234_5678,
          64'd8, 64'h0080_0000_0012_3456);
      run("R9 right 16-bit count 15", 5'(OP_SHR), 2'd1, 1'b0, 64'h8000_7FFF_FFFF_0001,
          64'd15, 64'h0001_0000_0001_0000);
      run("R9 right 16-bit count 16", 5'(OP_SHR), 2'd1, 1'b0, 64'h8000_7FFF_FFFF_0001,
          64'd16, 64'h0);
      run("R9 left 64-bit count 64", 5'(OP_SHL), 2'd3, 1'b0, 64'h1, 64'd64, 64'h0);
      run("R9 left 32-bit upper count bits", 5'(OP_SHL), 2'd2, 1'b0, 64'hFFFF_FFFF,
          64'h1_0000_0003, 64'h0);
   endtask

   task automatic t_sar;
      run("R10 arith right 16-bit", 5'(OP_SAR), 2'd1, 1'b0, 64'h8000_7FF0_FFF0_0123,
          64'd4, 64'hF800_07FF_FFFF_0012);
      run("R10 arith right 32-bit over-range", 5'(OP_SAR), 2'd2, 1'b0,
          64'h8000_0000_7FFF_FFFF, 64'd40, 64'hFFFF_FFFF_0000_0000);
   endtask

   task automatic t_logic;
      run("R11 and", 5'(OP_AND), 2'd0, 1'b0, 64'hF0F0_FF00_AAAA_1234,
          64'hFF00_F0F0_5555_FFFF, 64'hF000_F000_0000_1234);
      run("R11 andnot", 5'(OP_ANDN), 2'd2, 1'b0, 64'hF0F0_FF00_AAAA_1234,
          64'hFF00_F0F0_5555_FFFF, 64'h0F00_00F0_5555_EDCB);
      run("R11 or", 5'(OP_OR), 2'd1, 1'b0, 64'hF0F0_FF00_AAAA_1234,
          64'hFF00_F0F0_5555_FFFF, 64'hFFF0_FFF0_FFFF_FFFF);
      run("R11 xor", 5'(OP_XOR), 2'd3, 1'b0, 64'hF0F0_FF00_AAAA_1234,
          64'hFF00_F0F0_5555_FFFF, 64'h0FF0_0FF0_FFFF_EDCB);
   endtask

   task automatic t_unsup;
      run("R12 op 19", 5'd19, 2'd0, 1'b0, 64'hFFFF, 64'hFFFF, 64'h0);
      run("R12 op 31", 5'd31, 2'd1, 1'b1, 64'h1234, 64'h5678, 64'h0);
      run("R12 equal 64-bit", 5'(OP_CEQ), 2'd3, 1'b0, 64'h7, 64'h7, 64'h0);
      run("R12 pack 8-bit", 5'(OP_PACK), 2'd0, 1'b1, 64'h0102, 64'h0304, 64'h0);
      run("R12 unpack 64-bit", 5'(OP_UNLO), 2'd3, 1'b0, 64'h55, 64'hAA, 64'h0);
      run("R12 left 8-bit", 5'(OP_SHL), 2'd0, 1'b0, 64'h01, 64'd1, 64'h0);
      run("R12 arith right 64-bit", 5'(OP_SAR), 2'd3, 1'b0, 64'h8000_0000_0000_0000,
          64'd1, 64'h0);
      run("R12 arith right 8-bit", 5'(OP_SAR), 2'd0, 1'b0, 64'h80, 64'd1, 64'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_wrap();
      t_sat();
      t_cmp();
      t_pack();
      t_unpack();
      t_mul();
      t_madd();
      t_lshift();
      t_sar();
      t_logic();
      t_unsup();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule